// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block resolves which processors a software-generated interrupt reaches. A processor issues a 64-bit request word. The word names a 4-bit interrupt ID and a routing choice. It either broadcasts to every other processor, or it addresses a cluster by its upper affinity levels and picks members through a 16-bit mask of level-0 values. The block holds a fixed 24-bit affinity for each of a parameterised number of processors, and a group bit for each processor and each interrupt ID. A separate input says whether group-1 interrupts may be generated at all.

After it accepts a request, the block walks the processors one per cycle, starting from processor 0. Each processor that matches removes its level-0 bit from a working copy of the mask. When the request is not a broadcast, the walk stops as soon as that copy is empty. A matched processor receives a pending-set bit when its group bit for the ID is 0, or when group-1 generation is allowed. At the end of the walk, a one-cycle done pulse marks the pending-set vector and the interrupt ID as final. Both outputs then hold until the next request is accepted.

Top module: `swint_dispatch`

## Requirements
- R1: After reset, reqReady is 1, done is 0 and pendSet is all zeros.
- R2: The request word is decoded as follows: target mask in bits [15:0], affinity level 1 in [23:16], interrupt ID in [27:24], affinity level 2 in [39:32], broadcast flag in bit 40, affinity level 3 in [55:48]. All other bits are ignored.
- R3: reqReady is high only while idle. A request is accepted on a clock edge where reqValid and reqReady are both high. reqReady then stays low until done has pulsed high for exactly one cycle. reqReady is high again in the cycle after the done pulse.
- R4: When the broadcast flag is 1, every processor whose index differs from reqSender is targeted, and the sender never is.
- R5: When the broadcast flag is 0, processor i is targeted only if all of the following hold: the request's level 3 is zero (processors have an implicit level 3 of zero); the request's levels 2 and 1 equal bits [23:16] and [15:8] of the processor's affinity; and bit v of the working mask is set, where v is the processor's level-0 value in bits [7:0].
- R6: When the broadcast flag is 0, a processor whose level-0 affinity is 16 or more is never targeted.
- R7: Each targeted processor clears its level-0 bit from the working mask. A later processor with the same level-0 value is therefore not targeted by the same request.
- R8: Processor k is examined in the k-th cycle after acceptance, counting from 0. done goes high after k+1 clock edges, where k is the index of the last processor examined. For a broadcast request, k is always NUM_CPU-1. Otherwise, k is the first index after whose examination the working mask is zero, or NUM_CPU-1 if the mask never empties. A request with an empty target mask therefore ends after processor 0.
- R9: A targeted processor gets its pendSet bit only when cpuGroup[i*16+ID] is 0 or allowGroup1 is 1. Otherwise it is skipped, although it still clears its mask bit.
- R10: pendSet and pendId hold their values from the done pulse until the next request is accepted. pendId equals the accepted interrupt ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request word is presented |
| reqReady | output | 1 | Block is idle and will accept a request |
| reqWord | input | 64 | Request word (layout in R2) |
| reqSender | input | IDX_W | Index of the requesting processor |
| allowGroup1 | input | 1 | Group-1 generation permitted for this request |
| cpuAffinity | input | NUM_CPU*24 | Affinity of processor i in bits [i*24 +: 24] |
| cpuGroup | input | NUM_CPU*16 | Group bit of processor i for ID n at bit i*16+n |
| pendSet | output | NUM_CPU | Processors whose pending latch is to be set |
| pendId | output | 4 | Interrupt ID that goes with pendSet |
| done | output | 1 | One-cycle pulse: pendSet and pendId are final |

## Verification
The hardest case to reach is the interplay between the working mask and the walk length. Two processors share a level-0 value, a third has a level-0 value above 15, and a target bit names no processor. Together these decide whether the walk stops early or runs to the end. The stimulus builds an affinity table with exactly these features. It then sweeps target masks, all combinations of the upper levels, several IDs and both group-1 settings, and times every done pulse against a bench model of the walk.

// File: rtl/swd_pkg.sv
package swd_pkg;
  // request word field positions (decoded by the datapath)
  localparam int TGT_LSB  = 0;
  localparam int AFF1_LSB = 16;
  localparam int ID_LSB   = 24;
  localparam int AFF2_LSB = 32;
  localparam int MODE_BIT = 40;
  localparam int AFF3_LSB = 48;
  localparam int MASK_W   = 16;
  localparam int ID_W     = 4;
  localparam int AFFL_W   = 8;
  localparam int CPU_AFF_W = 24;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_DONE} swdState_t;

  typedef struct packed {
    logic load;   // capture a new request
    logic step;   // examine the processor at scanIdx
  } swdStrobe_t;
endpackage

// File: rtl/swd_ctrl.sv
module swd_ctrl
  import swd_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int IDX_W = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic earlyExit,
  output logic reqReady,
  output logic done,
  output swdStrobe_t strobe,
  output logic [IDX_W-1:0] scanIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CPU - 1);

  swdState_t state;
  logic scanEnd;

  assign scanEnd = earlyExit || (scanIdx == LAST_IDX);
  assign strobe.load = reqValid && (state == ST_IDLE);
  assign strobe.step = (state == ST_SCAN);
  assign reqReady = (state == ST_IDLE);
  assign done = (state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      scanIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (strobe.load) begin
          state <= ST_SCAN;
          scanIdx <= '0;
        end
        ST_SCAN: begin
          if (scanEnd) state <= ST_DONE;
          else scanIdx <= scanIdx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swd_datapath.sv
module swd_datapath
  import swd_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int IDX_W = 3
) (
  input  logic clk,
  input  logic rstN,
  input  swdStrobe_t strobe,
  input  logic [IDX_W-1:0] scanIdx,
  input  logic [63:0] reqWord,
  input  logic [IDX_W-1:0] reqSender,
  input  logic allowGroup1,
  input  logic [NUM_CPU*CPU_AFF_W-1:0] cpuAffinity,
  input  logic [NUM_CPU*MASK_W-1:0] cpuGroup,
  output logic earlyExit,
  output logic [NUM_CPU-1:0] pendSet,
  output logic [ID_W-1:0] pendId
);
  logic [MASK_W-1:0] tgtMask, maskNext;
  logic [AFFL_W-1:0] aff1Q, aff2Q, aff3Q;
  logic [ID_W-1:0] intId;
  logic bcastQ, allowQ;
  logic [IDX_W-1:0] senderQ;
  logic [NUM_CPU-1:0] pendVec;

  logic [CPU_AFF_W-1:0] affArr [NUM_CPU];
  logic [NUM_CPU-1:0] grpVec;

  genvar g;
  generate
    for (g = 0; g < NUM_CPU; g++) begin : gCpu
      assign affArr[g] = cpuAffinity[g*CPU_AFF_W +: CPU_AFF_W];
      assign grpVec[g] = cpuGroup[g*MASK_W + int'(intId)];
    end
  endgenerate

  logic [CPU_AFF_W-1:0] curAff;
  logic curGrp, upperMatch, lowMatch, hit, gateOk;

  assign curAff = affArr[scanIdx];
  assign curGrp = grpVec[scanIdx];
  assign upperMatch = (aff3Q == '0) && (aff2Q == curAff[23:16]) && (aff1Q == curAff[15:8]);
  assign lowMatch = (curAff[7:4] == 4'd0) && tgtMask[curAff[3:0]];
  assign hit = bcastQ ? (scanIdx != senderQ) : (upperMatch && lowMatch);
  assign gateOk = !curGrp || allowQ;
  assign maskNext = (hit && !bcastQ) ? (tgtMask & ~(16'd1 << curAff[3:0])) : tgtMask;
  assign earlyExit = !bcastQ && (maskNext == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtMask <= '0;
      aff1Q <= '0;
      aff2Q <= '0;
      aff3Q <= '0;
      intId <= '0;
      bcastQ <= 1'b0;
      allowQ <= 1'b0;
      senderQ <= '0;
      pendVec <= '0;
    end else if (strobe.load) begin
      tgtMask <= reqWord[TGT_LSB +: MASK_W];
      aff1Q <= reqWord[AFF1_LSB +: AFFL_W];
      aff2Q <= reqWord[AFF2_LSB +: AFFL_W];
      aff3Q <= reqWord[AFF3_LSB +: AFFL_W];
      intId <= reqWord[ID_LSB +: ID_W];
      bcastQ <= reqWord[MODE_BIT];
      allowQ <= allowGroup1;
      senderQ <= reqSender;
      pendVec <= '0;
    end else if (strobe.step) begin
      tgtMask <= maskNext;
      if (hit && gateOk) pendVec[scanIdx] <= 1'b1;
    end
  end

  assign pendSet = pendVec;
  assign pendId = intId;
endmodule

// File: rtl/swint_dispatch.sv
module swint_dispatch
  import swd_pkg::*;
#(
  parameter int NUM_CPU = 8,
  localparam int IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  output logic reqReady,
  input  logic [63:0] reqWord,
  input  logic [IDX_W-1:0] reqSender,
  input  logic allowGroup1,
  input  logic [NUM_CPU*24-1:0] cpuAffinity,
  input  logic [NUM_CPU*16-1:0] cpuGroup,
  output logic [NUM_CPU-1:0] pendSet,
  output logic [3:0] pendId,
  output logic done
);
  swdStrobe_t strobe;
  logic [IDX_W-1:0] scanIdx;
  logic earlyExit;

  swd_ctrl #(.NUM_CPU(NUM_CPU), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .earlyExit(earlyExit),
    .reqReady(reqReady), .done(done), .strobe(strobe), .scanIdx(scanIdx)
  );

  swd_datapath #(.NUM_CPU(NUM_CPU), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .scanIdx(scanIdx),
    .reqWord(reqWord), .reqSender(reqSender), .allowGroup1(allowGroup1),
    .cpuAffinity(cpuAffinity), .cpuGroup(cpuGroup), .earlyExit(earlyExit),
    .pendSet(pendSet), .pendId(pendId)
  );
endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
  parameter int NUM_CPU = 8,
  parameter int IDX_W = 3
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic [63:0] reqWord,
  input logic [IDX_W-1:0] reqSender,
  input logic allowGroup1,
  input logic [NUM_CPU*24-1:0] cpuAffinity,
  input logic [NUM_CPU*16-1:0] cpuGroup,
  input logic [NUM_CPU-1:0] pendSet,
  input logic [3:0] pendId,
  input logic done
);
  logic accept;
  logic capBcast, capAllow;
  logic [IDX_W-1:0] capSender;
  logic [3:0] capId;
  logic [NUM_CPU-1:0] g1Mask;

  assign accept = reqValid && reqReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capBcast <= 1'b0;
      capAllow <= 1'b0;
      capSender <= '0;
      capId <= '0;
    end else if (accept) begin
      capBcast <= reqWord[40];
      capAllow <= allowGroup1;
      capSender <= reqSender;
      capId <= reqWord[27:24];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CPU; g++) begin : gMask
      assign g1Mask[g] = cpuGroup[g*16 + int'(capId)];
    end
  endgenerate

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !reqReady); // R3
  AST_DONE_ONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && reqReady)); // R3
  AST_BCAST_SKIPS_SENDER: assert property (@(posedge clk) disable iff (!rstN)
    (done && capBcast) |-> !pendSet[capSender]); // R4
  AST_GROUP1_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (done && !capAllow) |-> ((pendSet & g1Mask) == '0)); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !reqValid) |=> ($stable(pendSet) && $stable(pendId))); // R10
  AST_ID_MATCHES: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pendId == capId)); // R10
endmodule

bind swint_dispatch swd_checker #(.NUM_CPU(NUM_CPU), .IDX_W(IDX_W)) uChk (.*);

// File: tb/swint_dispatch_test.sv
module swint_dispatch_test;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [63:0] reqWord = '0;
  logic [IW-1:0] reqSender = '0;
  logic allowGroup1 = 1'b0;
  logic [N*24-1:0] cpuAffinity;
  logic [N*16-1:0] cpuGroup;
  logic [N-1:0] pendSet;
  logic [3:0] pendId;
  logic done;

  int checks = 0;
  int errors = 0;
  logic [23:0] affTab [N];

  always #5 clk = ~clk;

  swint_dispatch #(.NUM_CPU(N)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWord(reqWord), .reqSender(reqSender), .allowGroup1(allowGroup1),
    .cpuAffinity(cpuAffinity), .cpuGroup(cpuGroup), .pendSet(pendSet),
    .pendId(pendId), .done(done)
  );

  function automatic logic grpOf(int c, int id);
    return ((c + id) % 3) == 0;
  endfunction

  function automatic logic [63:0] mkWord(logic [15:0] tgt, logic [7:0] a1, logic [3:0] id,
                                         logic [7:0] a2, logic mode, logic [7:0] a3);
    logic [63:0] w;
    w = 64'h00AA_0000_5000_0000 | {8'h0, 8'h0, 8'h0, 7'h55, 1'b0, 32'h0} ; // junk in ignored bits
    w[15:0] = tgt;
    w[23:16] = a1;
    w[27:24] = id;
    w[39:32] = a2;
    w[40] = mode;
    w[55:48] = a3;
    return w;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model(logic [63:0] w, int sender, logic allow,
                       output logic [N-1:0] vec, output int last);
    logic [15:0] m;
    logic bc, hit;
    vec = '0;
    m = w[15:0];
    bc = w[40];
    last = N - 1;
    for (int i = 0; i < N; i++) begin
      if (bc) hit = (i != sender);
      else hit = (w[55:48] == 8'd0) && (w[39:32] == affTab[i][23:16]) &&
                 (w[23:16] == affTab[i][15:8]) && (affTab[i][7:0] < 8'd16) &&
                 m[affTab[i][3:0]];
      if (hit) begin
        if (!bc) m[affTab[i][3:0]] = 1'b0;
        if (!grpOf(i, int'(w[27:24])) || allow) vec[i] = 1'b1;
      end
      if (!bc && m == 16'd0) begin
        last = i;
        break;
      end
    end
  endtask

  task automatic send(logic [63:0] w, int sender, logic allow, string tag);
    logic [N-1:0] expVec;
    int expLast, cnt;
    model(w, sender, allow, expVec, expLast);
    @(negedge clk);
    check({tag, " R3 ready idle"}, 64'(reqReady), 64'd1);
    reqWord = w;
    reqSender = IW'(sender);
    allowGroup1 = allow;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    reqWord = ~w;
    allowGroup1 = ~allow;
    cnt = 0;
    while (!done && cnt < 50) begin
      @(posedge clk);
      @(negedge clk);
      cnt++;
    end
    check({tag, " R8 latency"}, 64'(cnt), 64'(expLast + 1));
    check({tag, " pendSet"}, 64'(pendSet), 64'(expVec));
    check({tag, " R2/R10 pendId"}, 64'(pendId), 64'(w[27:24]));
    @(negedge clk);
    check({tag, " R3 ready after done"}, 64'(reqReady), 64'd1);
    check({tag, " R10 held"}, 64'(pendSet), 64'(expVec));
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] pats [8];
    affTab[0] = 24'h00_00_00;
    affTab[1] = 24'h00_00_01;
    affTab[2] = 24'h00_00_05;
    affTab[3] = 24'h00_01_00;
    affTab[4] = 24'h00_01_03;
    affTab[5] = 24'h00_00_01;
    affTab[6] = 24'h00_00_12;
    affTab[7] = 24'h01_00_02;
    for (int c = 0; c < N; c++) begin
      cpuAffinity[c*24 +: 24] = affTab[c];
      for (int id = 0; id < 16; id++) cpuGroup[c*16 + id] = grpOf(c, id);
    end
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h0002; pats[3] = 16'h0021;
    pats[4] = 16'h0009; pats[5] = 16'h0004; pats[6] = 16'h0001; pats[7] = 16'h0400;

    #1;
    check("R1 reset ready", 64'(reqReady), 64'd1);
    check("R1 reset done", 64'(done), 64'd0);
    check("R1 reset pendSet", 64'(pendSet), 64'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R7: cpu1 and cpu5 share level 0 = 1; only cpu1 gets it, walk ends at 1
    send(mkWord(16'h0002, 8'd0, 4'd1, 8'd0, 1'b0, 8'd0), 0, 1'b1, "R7 dup aff0");
    // R6: cpu6 has level 0 = 0x12, all-ones mask never reaches it
    send(mkWord(16'hFFFF, 8'd0, 4'd2, 8'd0, 1'b0, 8'd0), 0, 1'b1, "R6 aff0>=16");
    // R8: empty mask ends after processor 0
    send(mkWord(16'h0000, 8'd0, 4'd0, 8'd0, 1'b0, 8'd0), 3, 1'b1, "R8 empty mask");
    // R9: group-1 blocked
    send(mkWord(16'h0023, 8'd0, 4'd0, 8'd0, 1'b0, 8'd0), 0, 1'b0, "R9 group gate");

    for (int a3 = 0; a3 < 2; a3++)
      for (int a2 = 0; a2 < 2; a2++)
        for (int a1 = 0; a1 < 2; a1++)
          for (int p = 0; p < 8; p++)
            for (int id = 0; id < 16; id += 5)
              for (int al = 0; al < 2; al++)
                send(mkWord(pats[p], 8'(a1), 4'(id), 8'(a2), 1'b0, 8'(a3)), p, al[0],
                     "R2/R5/R6/R7/R9 targeted");

    for (int s = 0; s < N; s++)
      for (int id = 0; id < 16; id++)
        for (int al = 0; al < 2; al++)
          send(mkWord(16'(id * 37), 8'(s), 4'(id), 8'd3, 1'b1, 8'(al)), s, al[0],
               "R4/R9 broadcast");

    // R10: outputs stay put while idle
    repeat (5) @(negedge clk);
    check("R10 idle hold id", 64'(pendId), 64'd15);
    check("R3 idle ready", 64'(reqReady), 64'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule